// File: doc/BRIEF.md
# Calibration Output Gating Supervisor

This block sits in the sampling-clock domain next to a two-channel data converter and tells downstream capture logic when converted samples can be trusted. It watches the converter's calibration-running signal and the power-down controls of both channels. From these it produces a per-channel valid qualifier, forces the data and over-range outputs to zero while they are not valid, and keeps a sticky flag that says a fresh calibration is needed.

Each channel's effective power-down comes from its pin. When the extended-control mode is enabled, the channel's register bit is OR-ed in as well. Output is held invalid while calibration runs. It stays invalid for a fixed flush interval after calibration ends, so that results still in the pipeline are not captured. Power-down changes that disturb bias settling, and a full power-down during a calibration, raise the recalibration flag. Only a later calibration that finishes cleanly lowers it again. The block does not start calibrations, and it never touches the data clock.

Top module: `cal_gate_supervisor`

## Requirements
- R1: When `ext_ctl_en_i` is 1, each channel's `pd_eff_*_o` equals its pin OR its register bit, in the same cycle.
- R2: When `ext_ctl_en_i` is 0, each `pd_eff_*_o` follows its pin only, and the register bits have no effect.
- R3: While `cal_run_i` is 1, both valid outputs are 0 and all data and over-range outputs are 0.
- R4: In the first cycle with `cal_run_i` low after a calibration, and in the 59 cycles that follow (60 cycles in all, `FLUSH_CYCLES`), both valid outputs stay 0 and the data outputs stay 0. In the 61st cycle they become valid.
- R5: If calibration starts again during the flush interval, the full 60-cycle interval is counted again from its next falling edge.
- R6: A channel whose effective power-down is 1 has valid 0 and zero data and over-range outputs. The other channel is unaffected.
- R7: While a channel is valid, its data and over-range outputs equal its inputs in the same cycle.
- R8: After reset, `recal_req_o` is 1.
- R9: If both channels are powered down while `cal_run_i` is 1, `recal_req_o` is 1 from the next cycle. That calibration's falling edge does not clear it.
- R10: When any channel leaves power-down, `recal_req_o` is 1 from the next cycle.
- R11: When exactly one channel newly enters power-down, `recal_req_o` is 1 from the next cycle. Both channels entering together outside calibration do not set it.
- R12: `recal_req_o` clears one cycle after `cal_run_i` falls, but only for a calibration during which no power-down event occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cal_run_i | input | 1 | Converter calibration in progress |
| ext_ctl_en_i | input | 1 | Extended-control mode: register bits join the pins |
| pd_pin_a_i | input | 1 | Power-down pin, channel A |
| pd_pin_b_i | input | 1 | Power-down pin, channel B |
| pd_reg_a_i | input | 1 | Power-down register bit, channel A |
| pd_reg_b_i | input | 1 | Power-down register bit, channel B |
| data_a_i | input | DATA_W | Converted sample, channel A |
| data_b_i | input | DATA_W | Converted sample, channel B |
| ovr_a_i | input | 1 | Over-range, channel A |
| ovr_b_i | input | 1 | Over-range, channel B |
| pd_eff_a_o | output | 1 | Effective power-down, channel A |
| pd_eff_b_o | output | 1 | Effective power-down, channel B |
| valid_a_o | output | 1 | Channel A sample usable |
| valid_b_o | output | 1 | Channel B sample usable |
| data_a_o | output | DATA_W | Gated sample, channel A |
| data_b_o | output | DATA_W | Gated sample, channel B |
| ovr_a_o | output | 1 | Gated over-range, channel A |
| ovr_b_o | output | 1 | Gated over-range, channel B |
| recal_req_o | output | 1 | Recalibration needed (sticky) |

## Verification
The bench counts the exact length of the invalid window after a falling edge of `cal_run_i`. A counter that is off by one, or one that starts at the wrong edge, gives 59 or 61 and not 60. A calibration restarted in the middle of the flush must produce a full new window; a design that keeps the old count would release data about 30 cycles early. The recalibration tests separate a single channel entering power-down from both channels entering at once. They also check that an event inside a calibration survives that calibration's falling edge. A design with the wrong priority between setting and clearing would drop the flag and let compromised samples through.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

    localparam int unsigned NUM_CH = 2;

    typedef struct packed {
        logic              cal_q;
        logic [NUM_CH-1:0] pd_prev;
        logic              tainted;
        logic              recal;
    } trk_state_t;

endpackage

// File: rtl/cgs_pd_merge.sv
module cgs_pd_merge #(
    parameter int unsigned NUM_CH = 2
) (
    input  logic              ext_en_i,
    input  logic [NUM_CH-1:0] pin_i,
    input  logic [NUM_CH-1:0] reg_i,
    output logic [NUM_CH-1:0] eff_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_comb begin
            eff_o[c] = pin_i[c] | (ext_en_i & reg_i[c]);
        end
    end

endmodule

// File: rtl/cgs_flush_timer.sv
module cgs_flush_timer #(
    parameter int unsigned FLUSH_CYCLES = 60
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cal_run_i,
    output logic quiet_o
);

    localparam int unsigned CNT_W = $clog2(FLUSH_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(FLUSH_CYCLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cal_run_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        quiet_o = !cal_run_i && (cnt_q == '0);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/cgs_recal_tracker.sv
module cgs_recal_tracker
    import cgs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cal_run_i,
    input  logic [NUM_CH-1:0] pd_eff_i,
    output logic              recal_o
);

    trk_state_t s_d, s_q;
    logic [NUM_CH-1:0] entered;
    logic [NUM_CH-1:0] left;
    logic              all_down_in_cal;
    logic              event_seen;
    logic              cal_fall;

    always_comb begin
        s_d             = s_q;
        entered         = pd_eff_i & ~s_q.pd_prev;
        left            = s_q.pd_prev & ~pd_eff_i;
        all_down_in_cal = cal_run_i && (&pd_eff_i);
        event_seen      = (|left) || ($countones(entered) == 1) || all_down_in_cal;
        cal_fall        = s_q.cal_q && !cal_run_i;

        s_d.cal_q   = cal_run_i;
        s_d.pd_prev = pd_eff_i;

        if (cal_fall) begin
            s_d.tainted = 1'b0;
        end else if (cal_run_i && event_seen) begin
            s_d.tainted = 1'b1;
        end

        if (event_seen) begin
            s_d.recal = 1'b1;
        end else if (cal_fall && !s_q.tainted) begin
            s_d.recal = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q.cal_q   <= 1'b0;
            s_q.pd_prev <= '0;
            s_q.tainted <= 1'b0;
            s_q.recal   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign recal_o = s_q.recal;

endmodule

// File: rtl/cgs_out_gate.sv
module cgs_out_gate #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              quiet_i,
    input  logic              pd_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ovr_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ovr_o
);

    always_comb begin
        valid_o = quiet_i && !pd_i;
        data_o  = valid_o ? data_i : '0;
        ovr_o   = valid_o && ovr_i;
    end

endmodule

// File: rtl/cal_gate_supervisor.sv
module cal_gate_supervisor
    import cgs_pkg::*;
#(
    parameter int unsigned DATA_W       = 12,
    parameter int unsigned FLUSH_CYCLES = 60
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cal_run_i,
    input  logic              ext_ctl_en_i,
    input  logic              pd_pin_a_i,
    input  logic              pd_pin_b_i,
    input  logic              pd_reg_a_i,
    input  logic              pd_reg_b_i,
    input  logic [DATA_W-1:0] data_a_i,
    input  logic [DATA_W-1:0] data_b_i,
    input  logic              ovr_a_i,
    input  logic              ovr_b_i,
    output logic              pd_eff_a_o,
    output logic              pd_eff_b_o,
    output logic              valid_a_o,
    output logic              valid_b_o,
    output logic [DATA_W-1:0] data_a_o,
    output logic [DATA_W-1:0] data_b_o,
    output logic              ovr_a_o,
    output logic              ovr_b_o,
    output logic              recal_req_o
);

    logic [NUM_CH-1:0] pd_eff;
    logic [NUM_CH-1:0] valid;
    logic [NUM_CH-1:0] ovr_in, ovr_out;
    logic [NUM_CH-1:0][DATA_W-1:0] din, dout;
    logic quiet;

    assign din    = {data_b_i, data_a_i};
    assign ovr_in = {ovr_b_i, ovr_a_i};

    cgs_pd_merge #(.NUM_CH(NUM_CH)) u_merge (
        .ext_en_i (ext_ctl_en_i),
        .pin_i    ({pd_pin_b_i, pd_pin_a_i}),
        .reg_i    ({pd_reg_b_i, pd_reg_a_i}),
        .eff_o    (pd_eff)
    );

    cgs_flush_timer #(.FLUSH_CYCLES(FLUSH_CYCLES)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cal_run_i (cal_run_i),
        .quiet_o   (quiet)
    );

    cgs_recal_tracker u_track (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .cal_run_i (cal_run_i),
        .pd_eff_i  (pd_eff),
        .recal_o   (recal_req_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
        cgs_out_gate #(.DATA_W(DATA_W)) u_gate (
            .quiet_i (quiet),
            .pd_i    (pd_eff[c]),
            .data_i  (din[c]),
            .ovr_i   (ovr_in[c]),
            .valid_o (valid[c]),
            .data_o  (dout[c]),
            .ovr_o   (ovr_out[c])
        );
    end

    assign pd_eff_a_o = pd_eff[0];
    assign pd_eff_b_o = pd_eff[1];
    assign valid_a_o  = valid[0];
    assign valid_b_o  = valid[1];
    assign data_a_o   = dout[0];
    assign data_b_o   = dout[1];
    assign ovr_a_o    = ovr_out[0];
    assign ovr_b_o    = ovr_out[1];

endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
    parameter int unsigned DATA_W       = 12,
    parameter int unsigned FLUSH_CYCLES = 60
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cal_run_i,
    input logic              ext_ctl_en_i,
    input logic              pd_pin_a_i,
    input logic              pd_pin_b_i,
    input logic              pd_eff_a_o,
    input logic              pd_eff_b_o,
    input logic              valid_a_o,
    input logic              valid_b_o,
    input logic [DATA_W-1:0] data_a_o,
    input logic [DATA_W-1:0] data_b_o,
    input logic              ovr_a_o,
    input logic              ovr_b_o,
    input logic              recal_req_o
);

    localparam int unsigned CW = $clog2(FLUSH_CYCLES + 1);
    logic [CW-1:0] window_left;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            window_left <= '0;
        end else if (cal_run_i) begin
            window_left <= CW'(FLUSH_CYCLES);
        end else if (window_left != '0) begin
            window_left <= window_left - 1'b1;
        end
    end

    AST_PIN_ONLY_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_ctl_en_i |-> (pd_eff_a_o == pd_pin_a_i)); // R2
    AST_PIN_ONLY_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ext_ctl_en_i |-> (pd_eff_b_o == pd_pin_b_i)); // R2
    AST_PIN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pd_pin_a_i || pd_pin_b_i) |-> (pd_eff_a_o || pd_eff_b_o)); // R1
    AST_CAL_BLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cal_run_i |-> (!valid_a_o && !valid_b_o && data_a_o == '0 && data_b_o == '0
                       && !ovr_a_o && !ovr_b_o)); // R3
    AST_FLUSH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (window_left != '0) |-> (!valid_a_o && !valid_b_o)); // R4
    AST_PD_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pd_eff_a_o || pd_eff_b_o) |-> !(pd_eff_a_o && valid_a_o) && !(pd_eff_b_o && valid_b_o)); // R6
    AST_GATED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_a_o |-> (data_a_o == '0 && !ovr_a_o))); // R6
    AST_BOTH_DOWN_CAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cal_run_i && pd_eff_a_o && pd_eff_b_o) |=> recal_req_o); // R9
    AST_LEAVE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pd_eff_a_o && $past(pd_eff_a_o)) |=> recal_req_o); // R10

endmodule

bind cal_gate_supervisor cgs_checker #(
    .DATA_W(DATA_W),
    .FLUSH_CYCLES(FLUSH_CYCLES)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cal_run_i    (cal_run_i),
    .ext_ctl_en_i (ext_ctl_en_i),
    .pd_pin_a_i   (pd_pin_a_i),
    .pd_pin_b_i   (pd_pin_b_i),
    .pd_eff_a_o   (pd_eff_a_o),
    .pd_eff_b_o   (pd_eff_b_o),
    .valid_a_o    (valid_a_o),
    .valid_b_o    (valid_b_o),
    .data_a_o     (data_a_o),
    .data_b_o     (data_b_o),
    .ovr_a_o      (ovr_a_o),
    .ovr_b_o      (ovr_b_o),
    .recal_req_o  (recal_req_o)
);

// File: tb/cal_gate_supervisor_tb.sv
`timescale 1ns/1ps
module cal_gate_supervisor_tb_top;

    localparam int DW    = 12;
    localparam int FLUSH = 60;
    localparam logic [DW-1:0] DA = 12'hA5C;
    localparam logic [DW-1:0] DB = 12'h3F1;

    // {ext, pin_a, reg_a, pin_b, reg_b, exp_pd_a, exp_pd_b}
    localparam logic [6:0] VEC [8] = '{
        7'b0_0_0_0_0_0_0,
        7'b0_0_1_0_1_0_0,
        7'b0_1_0_0_1_1_0,
        7'b1_0_1_0_0_1_0,
        7'b1_0_0_1_0_0_1,
        7'b1_0_0_0_1_0_1,
        7'b1_1_1_0_0_1_0,
        7'b1_0_0_0_0_0_0
    };

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic cal_run_i = 1'b0, ext_ctl_en_i = 1'b0;
    logic pd_pin_a_i = 1'b0, pd_pin_b_i = 1'b0, pd_reg_a_i = 1'b0, pd_reg_b_i = 1'b0;
    logic [DW-1:0] data_a_i = DA, data_b_i = DB;
    logic ovr_a_i = 1'b1, ovr_b_i = 1'b1;
    logic pd_eff_a_o, pd_eff_b_o, valid_a_o, valid_b_o, ovr_a_o, ovr_b_o, recal_req_o;
    logic [DW-1:0] data_a_o, data_b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk_i = ~clk_i;

    cal_gate_supervisor #(.DATA_W(DW), .FLUSH_CYCLES(FLUSH)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk_i);
        #1;
    endtask

    task automatic settle();
        @(negedge clk_i);
    endtask

    // Drive cal for len cycles, drop it, count invalid cycles and the recal flag
    // seen in the fall cycle (pre) and the cycle after (post).
    task automatic run_cal(input int len, input int mid_pd, output int n_inv,
                           output logic pre, output logic post);
        cal_run_i = 1'b1;
        for (int i = 0; i < len; i++) begin
            if (mid_pd != 0 && i == 1) begin
                pd_pin_a_i = 1'b1;
                pd_pin_b_i = 1'b1;
            end
            settle();
            chk(!valid_a_o && !valid_b_o && data_a_o == 0 && data_b_o == 0 && !ovr_a_o,
                "R3", "blank during cal", int'(valid_a_o), 0);
            cyc();
        end
        cal_run_i = 1'b0;
        n_inv = 0;
        pre = 1'b0;
        post = 1'b0;
        for (int k = 0; k < 200; k++) begin
            settle();
            if (k == 0) pre = recal_req_o;
            if (k == 1) post = recal_req_o;
            if (valid_a_o || mid_pd != 0 && k > 70) break;
            if (data_a_o != 0) chk(0, "R4", "data zero in flush", int'(data_a_o), 0);
            n_inv++;
            cyc();
        end
        cyc();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int inv;
        logic pre, post;
        repeat (3) cyc();
        rst_ni = 1'b1;
        settle();
        chk(recal_req_o == 1'b1, "R8", "recal after reset", int'(recal_req_o), 1);
        chk(valid_a_o && data_a_o == DA && ovr_a_o, "R7", "idle pass-through",
            int'(data_a_o), int'(DA));
        cyc();

        // vector table: power-down merge and per-channel gating
        for (int v = 0; v < 8; v++) begin
            {ext_ctl_en_i, pd_pin_a_i, pd_reg_a_i, pd_pin_b_i, pd_reg_b_i} = VEC[v][6:2];
            settle();
            chk(pd_eff_a_o == VEC[v][1] && pd_eff_b_o == VEC[v][0],
                VEC[v][6] ? "R1" : "R2", $sformatf("pd merge vec %0d", v),
                int'({pd_eff_a_o, pd_eff_b_o}), int'(VEC[v][1:0]));
            chk(valid_a_o == !VEC[v][1] && valid_b_o == !VEC[v][0] &&
                data_a_o == (VEC[v][1] ? 0 : DA) && data_b_o == (VEC[v][0] ? 0 : DB),
                "R6", $sformatf("gating vec %0d", v),
                int'({valid_a_o, valid_b_o}), int'(~VEC[v][1:0]));
            cyc();
        end
        {ext_ctl_en_i, pd_pin_a_i, pd_reg_a_i, pd_pin_b_i, pd_reg_b_i} = '0;
        cyc();

        // clean calibration: exact flush length and flag clear
        run_cal(5, 0, inv, pre, post);
        chk(inv == FLUSH, "R4", "flush length", inv, FLUSH);
        chk(pre == 1'b1 && post == 1'b0, "R12", "clean cal clears recal", int'(post), 0);
        settle();
        chk(valid_b_o && data_b_o == DB, "R7", "valid after flush", int'(data_b_o), int'(DB));
        cyc();

        // exactly one channel enters power-down
        pd_pin_a_i = 1'b1;
        settle();
        chk(recal_req_o == 1'b0, "R11", "no set before edge", int'(recal_req_o), 0);
        chk(!valid_a_o && valid_b_o && data_b_o == DB, "R6", "other channel unaffected",
            int'(valid_b_o), 1);
        cyc();
        settle();
        chk(recal_req_o == 1'b1, "R11", "single enter sets recal", int'(recal_req_o), 1);
        cyc();
        run_cal(3, 0, inv, pre, post);
        chk(recal_req_o == 1'b0 && post == 1'b0, "R12", "clear with A held down",
            int'(recal_req_o), 0);

        // leaving power-down
        pd_pin_a_i = 1'b0;
        cyc();
        settle();
        chk(recal_req_o == 1'b1, "R10", "leave sets recal", int'(recal_req_o), 1);
        cyc();
        run_cal(3, 0, inv, pre, post);

        // both enter together outside calibration
        pd_pin_a_i = 1'b1;
        pd_pin_b_i = 1'b1;
        cyc();
        settle();
        chk(recal_req_o == 1'b0, "R11", "joint entry outside cal", int'(recal_req_o), 0);
        cyc();
        pd_pin_a_i = 1'b0;
        pd_pin_b_i = 1'b0;
        cyc();
        settle();
        chk(recal_req_o == 1'b1, "R10", "joint leave sets recal", int'(recal_req_o), 1);
        cyc();
        run_cal(3, 0, inv, pre, post);

        // both down during calibration: flag survives the falling edge
        run_cal(4, 1, inv, pre, post);
        chk(pre == 1'b1 && post == 1'b1, "R9", "compromised cal keeps recal",
            int'(post), 1);
        pd_pin_a_i = 1'b0;
        pd_pin_b_i = 1'b0;
        cyc();
        run_cal(3, 0, inv, pre, post);
        chk(recal_req_o == 1'b0, "R12", "recovery cal clears", int'(recal_req_o), 0);

        // restart during flush
        cal_run_i = 1'b1;
        repeat (4) cyc();
        cal_run_i = 1'b0;
        repeat (30) cyc();
        settle();
        chk(!valid_a_o, "R4", "mid flush invalid", int'(valid_a_o), 0);
        cyc();
        run_cal(3, 0, inv, pre, post);
        chk(inv == FLUSH, "R5", "restarted flush length", inv, FLUSH);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule